// File: doc/BRIEF.md
# System Management Interrupt Entry Controller

This controller sits next to a simple in-order core. It decides when the core leaves normal execution and enters its management mode. Management requests arrive either on a dedicated pin or as a message on the interrupt-message port. Both sources feed one pending request, and that request is arbitrated against the non-maskable and maskable interrupt lines. The controller is non-reentrant. Requests that arrive while the core waits for its startup message are held and are taken ahead of that message. A one-instruction shadow after an interrupt-enable or stack-segment load defers a request.

Once a request is taken, the controller stalls fetch until every in-flight instruction has retired and every store has completed. It then captures the operating mode the core was in and asks the save logic to store the context. When the save is acknowledged, it starts the handler. A resume command ends the mode and presents the captured operating mode for restoration. Context layout, handler code and instruction decode are handled elsewhere.

Top module: `smi_entry_ctrl`

## Requirements
- R1: A request on `req_pin` or on `req_msg`, or on both together, sets the same single pending request. With no mask in force it is taken in the same cycle, and `drain_hold` rises after the next clock edge.
- R2: In a cycle where a management request is being taken or is pending in the idle state, `grant_nmi` and `grant_intr` stay 0. Otherwise `grant_nmi` follows `nmi_req`. `grant_intr` is 1 only when `intr_req` and `intr_en` are both 1 and `nmi_req` is 0. Both grants are 0 outside the idle state.
- R3: While management mode is active, a new request causes no new entry. No new `drain_hold` phase starts, and no new `handler_start` is raised, until the core leaves the mode.
- R4: While `wait_startup` is 1 and no startup message has arrived, a request is not taken (`drain_hold` stays 0) but is kept pending.
- R5: When `startup_msg` arrives with a request pending, the request is taken in that cycle and `startup_go` stays 0 through the whole management episode. `startup_go` pulses for one cycle, one cycle after the controller is back in the idle state. With nothing pending, `startup_go` pulses on the cycle after `startup_msg`.
- R6: A request in the cycle `shadow_set` is 1 is not taken, nor in any later cycle until `instr_retire` has marked the next instruction. It is taken in the cycle after that retire.
- R7: After a request is taken, `drain_hold` stays 1 and `save_req` stays 0 until a clock edge at which both `pipe_empty` and `stores_empty` are 1.
- R8: `save_req` stays 1 until `save_done` is seen. `handler_start` is then 1 for exactly the first cycle in the mode.
- R9: `smm_active` is 1 from the first `save_req` cycle until the end of the `restore_valid` cycle, and 0 after that.
- R10: One cycle after `resume_cmd`, `restore_valid` is 1 for one cycle. `restore_mode` then equals the value of `cur_mode` at the edge that ended the drain. The encodings are 0 for real, 1 for protected and 2 for virtual. Later changes to `cur_mode` do not affect it.
- R11: A request arriving while draining or saving merges into the entry already under way, and no second entry follows.
- R12: With `HOLD_IN_MODE`=1 (the default), a request seen while in the mode is kept and taken on the first idle cycle after exit. With 0, it is dropped.
- R13: After reset, `drain_hold`, `save_req`, `handler_start`, `smm_active`, `restore_valid` and `startup_go` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pin | input | 1 | Request from the dedicated pin |
| req_msg | input | 1 | Request delivered by the interrupt-message port |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| intr_req | input | 1 | Maskable interrupt pending |
| intr_en | input | 1 | Maskable interrupts enabled |
| shadow_set | input | 1 | Retiring instruction opens a one-instruction shadow |
| instr_retire | input | 1 | An instruction retires this cycle |
| wait_startup | input | 1 | Core is waiting for its startup message |
| startup_msg | input | 1 | Startup message arrives |
| pipe_empty | input | 1 | No instructions in flight |
| stores_empty | input | 1 | No stores outstanding |
| cur_mode | input | MODE_W | Current operating mode (0 real, 1 protected, 2 virtual) |
| save_done | input | 1 | Context save finished |
| resume_cmd | input | 1 | Resume instruction executed |
| grant_nmi | output | 1 | Non-maskable interrupt accepted this cycle |
| grant_intr | output | 1 | Maskable interrupt accepted this cycle |
| drain_hold | output | 1 | Stall fetch while the pipeline drains |
| save_req | output | 1 | Context save requested |
| handler_start | output | 1 | One-cycle pulse that starts the handler |
| smm_active | output | 1 | Management mode active indicator |
| restore_valid | output | 1 | Restore the operating mode now |
| restore_mode | output | MODE_W | Operating mode to restore |
| startup_go | output | 1 | Startup message released to the core |

## Verification
A lost or stale pending bit shows one edge after the request cycle. `drain_hold` either fails to rise, or rises in a cycle where a mask or the mode forbids it. A sequencer stuck in the wrong state shows within one cycle as `save_req`, `handler_start` or `smm_active` out of step with `save_done` and `resume_cmd`. A wrongly captured operating mode shows only at the end of an episode, on `restore_mode` in the `restore_valid` cycle. A misordered startup release shows as `startup_go` pulsing inside the episode rather than one cycle after exit.

// File: rtl/smi_pkg.sv
package smi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_DRAIN   = 3'd1,
      ST_SAVE    = 3'd2,
      ST_IN_MODE = 3'd3,
      ST_RESUME  = 3'd4
   } smi_state_e;
endpackage

// File: rtl/smi_src_pend.sv
// Request capture, masking and startup-message hold.
module smi_src_pend
   import smi_pkg::*;
#(
   parameter bit HOLD_IN_MODE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_pin,
   input  logic       req_msg,
   input  logic       shadow_set,
   input  logic       instr_retire,
   input  logic       wait_startup,
   input  logic       startup_msg,
   input  smi_state_e state,
   output logic       want,
   output logic       take,
   output logic       startup_go
);
   logic pend_q, shadow_q, sup_q;
   logic req_now, capture_ok, shadow_on, sup_seen, unmasked, sup_fire, idle;

   assign idle    = (state == ST_IDLE);
   assign req_now = req_pin | req_msg;

   generate
      if (HOLD_IN_MODE) begin : g_hold
         assign capture_ok = idle || (state == ST_IN_MODE) || (state == ST_RESUME);
      end else begin : g_drop
         assign capture_ok = idle;
      end
   endgenerate

   assign shadow_on = shadow_q | shadow_set;
   assign sup_seen  = startup_msg | sup_q;
   assign unmasked  = !shadow_on && (!wait_startup || sup_seen);
   assign want      = idle && (pend_q || req_now);
   assign take      = want && unmasked;
   assign sup_fire  = idle && sup_seen && !want;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         shadow_q   <= 1'b0;
         sup_q      <= 1'b0;
         startup_go <= 1'b0;
      end else begin
         pend_q     <= take ? 1'b0 : (pend_q | (req_now & capture_ok));
         shadow_q   <= shadow_set ? 1'b1 : (instr_retire ? 1'b0 : shadow_q);
         sup_q      <= sup_fire ? 1'b0 : (sup_q | startup_msg);
         startup_go <= sup_fire;
      end
   end

   assert_shadow_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_set |-> !take);
   assert_wait_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && wait_startup && !sup_seen && req_now) |=> pend_q);
   assert_startup_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      startup_go |-> $past(idle && !want));
endmodule

// File: rtl/smi_prio.sv
// Fixed priority: management request, then NMI, then maskable interrupt.
module smi_prio (
   input  logic idle,
   input  logic want,
   input  logic nmi_req,
   input  logic intr_req,
   input  logic intr_en,
   output logic grant_nmi,
   output logic grant_intr
);
   logic open_slot;
   assign open_slot  = idle && !want;
   assign grant_nmi  = open_slot && nmi_req;
   assign grant_intr = open_slot && !nmi_req && intr_req && intr_en;
endmodule

// File: rtl/smi_seq.sv
// Entry / exit sequencer and prior-mode register.
module smi_seq
   import smi_pkg::*;
#(
   parameter int unsigned MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              drain_ok,
   input  logic              save_done,
   input  logic              resume_cmd,
   input  logic [MODE_W-1:0] cur_mode,
   output smi_state_e        state,
   output logic              drain_hold,
   output logic              save_req,
   output logic              handler_start,
   output logic              smm_active,
   output logic              restore_valid,
   output logic [MODE_W-1:0] restore_mode
);
   smi_state_e        nxt;
   logic [MODE_W-1:0] mode_q;
   logic              hs_q;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (take)       nxt = ST_DRAIN;
         ST_DRAIN:   if (drain_ok)   nxt = ST_SAVE;
         ST_SAVE:    if (save_done)  nxt = ST_IN_MODE;
         ST_IN_MODE: if (resume_cmd) nxt = ST_RESUME;
         ST_RESUME:                  nxt = ST_IDLE;
         default:                    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= '0;
         hs_q   <= 1'b0;
      end else begin
         state <= nxt;
         hs_q  <= (state == ST_SAVE) && save_done;
         if (state == ST_DRAIN && drain_ok) mode_q <= cur_mode;
      end
   end

   assign drain_hold    = (state == ST_DRAIN);
   assign save_req      = (state == ST_SAVE);
   assign smm_active    = (state == ST_SAVE) || (state == ST_IN_MODE) || (state == ST_RESUME);
   assign restore_valid = (state == ST_RESUME);
   assign restore_mode  = mode_q;
   assign handler_start = hs_q;

   assert_no_reenter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IN_MODE && !resume_cmd) |=> (state == ST_IN_MODE));
   assert_drain_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(save_req) |-> $past(drain_ok));
   assert_one_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      handler_start |=> !handler_start);
   assert_exit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |=> !smm_active);
endmodule

// File: rtl/smi_entry_ctrl.sv
module smi_entry_ctrl
   import smi_pkg::*;
#(
   parameter int unsigned MODE_W       = 2,
   parameter bit          HOLD_IN_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_pin,
   input  logic              req_msg,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic              intr_en,
   input  logic              shadow_set,
   input  logic              instr_retire,
   input  logic              wait_startup,
   input  logic              startup_msg,
   input  logic              pipe_empty,
   input  logic              stores_empty,
   input  logic [MODE_W-1:0] cur_mode,
   input  logic              save_done,
   input  logic              resume_cmd,
   output logic              grant_nmi,
   output logic              grant_intr,
   output logic              drain_hold,
   output logic              save_req,
   output logic              handler_start,
   output logic              smm_active,
   output logic              restore_valid,
   output logic [MODE_W-1:0] restore_mode,
   output logic              startup_go
);
   generate
      if (MODE_W < 2) begin : g_bad_mode_w
         $error("smi_entry_ctrl: MODE_W must be at least 2");
      end
   endgenerate

   smi_state_e state;
   logic       want, take, drain_ok;

   assign drain_ok = pipe_empty && stores_empty;

   smi_src_pend #(.HOLD_IN_MODE(HOLD_IN_MODE)) u_src (
      .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .req_msg(req_msg),
      .shadow_set(shadow_set), .instr_retire(instr_retire),
      .wait_startup(wait_startup), .startup_msg(startup_msg),
      .state(state), .want(want), .take(take), .startup_go(startup_go)
   );

   smi_prio u_prio (
      .idle(state == ST_IDLE), .want(want), .nmi_req(nmi_req),
      .intr_req(intr_req), .intr_en(intr_en),
      .grant_nmi(grant_nmi), .grant_intr(grant_intr)
   );

   smi_seq #(.MODE_W(MODE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .take(take), .drain_ok(drain_ok),
      .save_done(save_done), .resume_cmd(resume_cmd), .cur_mode(cur_mode),
      .state(state), .drain_hold(drain_hold), .save_req(save_req),
      .handler_start(handler_start), .smm_active(smm_active),
      .restore_valid(restore_valid), .restore_mode(restore_mode)
   );

   assert_smi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !(grant_nmi || grant_intr));
   assert_take_enters_R1: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> drain_hold);
   assert_grants_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant_nmi, grant_intr}));
endmodule

// File: tb/sim_smi_entry_ctrl.sv
module sim_smi_entry_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_pin = 0, req_msg = 0, nmi_req = 0, intr_req = 0, intr_en = 0;
   logic shadow_set = 0, instr_retire = 0, wait_startup = 0, startup_msg = 0;
   logic pipe_empty = 1, stores_empty = 1, save_done = 0, resume_cmd = 0;
   logic [1:0] cur_mode = 2'd0;
   logic grant_nmi, grant_intr, drain_hold, save_req, handler_start;
   logic smm_active, restore_valid, startup_go;
   logic [1:0] restore_mode;
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   smi_entry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .req_msg(req_msg),
      .nmi_req(nmi_req), .intr_req(intr_req), .intr_en(intr_en),
      .shadow_set(shadow_set), .instr_retire(instr_retire),
      .wait_startup(wait_startup), .startup_msg(startup_msg),
      .pipe_empty(pipe_empty), .stores_empty(stores_empty), .cur_mode(cur_mode),
      .save_done(save_done), .resume_cmd(resume_cmd),
      .grant_nmi(grant_nmi), .grant_intr(grant_intr), .drain_hold(drain_hold),
      .save_req(save_req), .handler_start(handler_start), .smm_active(smm_active),
      .restore_valid(restore_valid), .restore_mode(restore_mode),
      .startup_go(startup_go)
   );

   // {pin, msg, nmi, intr, intr_en} -> {enter, grant_nmi, grant_intr}
   localparam logic [7:0] VEC [0:8] = '{
      8'b00000_000, 8'b00100_010, 8'b00011_001, 8'b00010_000, 8'b00111_010,
      8'b10111_100, 8'b01111_100, 8'b11000_100, 8'b01000_100
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   // Starts just after the edge into SAVE has been observed.
   task automatic exit_from_save(input int exp_mode);
      save_done = 1;
      tick; save_done = 0; #5;
      chk("R8 handler_start first cycle", int'(handler_start), 1);
      chk("R8 save_req dropped", int'(save_req), 0);
      resume_cmd = 1;
      tick; resume_cmd = 0; #5;
      chk("R10 restore_valid", int'(restore_valid), 1);
      chk("R10 restore_mode", int'(restore_mode), exp_mode);
      chk("R9 active during restore", int'(smm_active), 1);
      tick; #5;
      chk("R9 active cleared", int'(smm_active), 0);
      chk("R10 restore_valid one cycle", int'(restore_valid), 0);
   endtask

   task automatic finish_from_drain(input int exp_mode);
      tick; #5;
      chk("R8 save_req", int'(save_req), 1);
      chk("R9 active in save", int'(smm_active), 1);
      exit_from_save(exp_mode);
   endtask

   initial begin
      #(20 * 5000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) tick;
      #5;
      chk("R13 drain_hold reset", int'(drain_hold), 0);
      chk("R13 save_req reset", int'(save_req), 0);
      chk("R13 handler_start reset", int'(handler_start), 0);
      chk("R13 smm_active reset", int'(smm_active), 0);
      chk("R13 restore_valid reset", int'(restore_valid), 0);
      chk("R13 startup_go reset", int'(startup_go), 0);
      rst_n = 1;

      // R1 / R2 / R10 table
      for (int i = 0; i < 9; i++) begin
         tick;
         {req_pin, req_msg, nmi_req, intr_req, intr_en} = VEC[i][7:3];
         cur_mode = 2'(i % 3);
         #5;
         chk("R2 grant_nmi", int'(grant_nmi), int'(VEC[i][1]));
         chk("R2 grant_intr", int'(grant_intr), int'(VEC[i][0]));
         tick;
         {req_pin, req_msg, nmi_req, intr_req, intr_en} = 5'b0;
         #5;
         chk("R1 entry", int'(drain_hold), int'(VEC[i][2]));
         if (VEC[i][2]) finish_from_drain(i % 3);
      end

      // R7 drain wait, R10 mode captured at end of drain
      cur_mode = 2'd2; pipe_empty = 0; stores_empty = 0;
      tick; req_msg = 1;
      tick; req_msg = 0; #5;
      chk("R7 drain_hold", int'(drain_hold), 1);
      tick; #5;
      chk("R7 no save while busy", int'(save_req), 0);
      pipe_empty = 1;
      tick; #5;
      chk("R7 waits for stores", int'(save_req), 0);
      chk("R7 still holding", int'(drain_hold), 1);
      stores_empty = 1;
      tick; #5;
      chk("R7 save after drain", int'(save_req), 1);
      cur_mode = 2'd1;
      exit_from_save(2);

      // R6 shadow
      tick; shadow_set = 1; req_pin = 1;
      tick; shadow_set = 0; req_pin = 0; instr_retire = 1; #5;
      chk("R6 blocked in shadow", int'(drain_hold), 0);
      tick; instr_retire = 0; #5;
      chk("R6 blocked until retire", int'(drain_hold), 0);
      tick; #5;
      chk("R6 taken after shadow", int'(drain_hold), 1);
      finish_from_drain(1);

      // R4 / R5 startup wait with pended request
      wait_startup = 1;
      tick; req_pin = 1;
      tick; req_pin = 0; #5;
      chk("R4 masked in startup wait", int'(drain_hold), 0);
      tick; #5;
      chk("R4 still masked", int'(drain_hold), 0);
      chk("R5 no early startup_go", int'(startup_go), 0);
      startup_msg = 1;
      tick; startup_msg = 0; #5;
      chk("R5 pended request first", int'(drain_hold), 1);
      chk("R5 startup held", int'(startup_go), 0);
      tick; #5;
      chk("R5 startup held in save", int'(startup_go), 0);
      exit_from_save(1);
      chk("R5 startup not yet", int'(startup_go), 0);
      tick; #5;
      chk("R5 startup after exit", int'(startup_go), 1);
      tick; #5;
      chk("R5 startup one pulse", int'(startup_go), 0);
      // startup with nothing pending
      startup_msg = 1;
      tick; startup_msg = 0; #5;
      chk("R5 plain startup_go", int'(startup_go), 1);
      chk("R5 no entry", int'(drain_hold), 0);
      wait_startup = 0;

      // R11 merge during save
      cur_mode = 2'd0;
      tick; req_pin = 1;
      tick; req_pin = 0;
      tick; #5;
      chk("R11 in save", int'(save_req), 1);
      req_msg = 1; save_done = 1;
      tick; req_msg = 0; save_done = 0; resume_cmd = 1;
      tick; resume_cmd = 0;
      tick; #5;
      chk("R11 exited", int'(smm_active), 0);
      tick; #5;
      chk("R11 no second entry", int'(drain_hold), 0);

      // R3 / R12 request inside the mode
      tick; req_pin = 1;
      tick; req_pin = 0;
      tick; save_done = 1;
      tick; save_done = 0; req_pin = 1;
      tick; req_pin = 0; #5;
      chk("R3 no restart", int'(handler_start), 0);
      chk("R3 no drain in mode", int'(drain_hold), 0);
      chk("R3 still active", int'(smm_active), 1);
      resume_cmd = 1;
      tick; resume_cmd = 0;
      tick; #5;
      chk("R12 idle after exit", int'(smm_active), 0);
      tick; #5;
      chk("R12 held request re-enters", int'(drain_hold), 1);
      finish_from_drain(0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule